// File: doc/BRIEF.md
# Pipelined Fixed-Point Fractional Multiplier Unit

This block is a signed multiplier for 16-bit two's-complement words in a 1.5.10 layout: one sign bit, five integer bits and ten fraction bits. It is a function unit that a data move starts, with no opcode. One operand is parked in an operand register. Writing the other operand to the trigger port starts a multiply. A mode bit that travels with the trigger picks one of two results. The fractional result is already realigned to 1.5.10, so no shift has to follow. The integer result is the low half of the full product.

The unit is fully pipelined. It accepts a new trigger on every clock, and each trigger produces one result two cycles later, marked by a one-cycle valid strobe. The operand register keeps its value until it is written again, so one coefficient can feed a long run of triggers. In fractional mode, a product that does not fit in 1.5.10 is clamped to the largest positive or the most negative word. No flag is raised when this happens.

Top module: `fxmul_unit`

## Requirements
- R1: With `trig_frac`=1 and no overflow, the result equals floor(A*B / 1024). A is the operand register value and B is the trigger word, both read as signed 1.5.10 words. This is product bits [25:10].
- R2: With `trig_frac`=1, a scaled product above 32767 gives 0x7FFF, and one below -32768 gives 0x8000.
- R3: With `trig_frac`=0, the result is bits [15:0] of the signed 32-bit product, wrapping silently.
- R4: An operation starts only on a cycle with `trig_we`=1. `trig_frac` and `trig_data` are sampled on that cycle alone. A mode change on a cycle without a trigger has no effect on any result.
- R5: `res_valid` is high for exactly one cycle, two clock edges after the edge that samples each trigger. Triggers on consecutive cycles give results on consecutive cycles.
- R6: The operand register is loaded only when `opnd_we`=1 and holds its value otherwise. Any number of later triggers reuse it.
- R7: When `opnd_we` and `trig_we` are both high in one cycle, that trigger multiplies by the newly written operand.
- R8: `res_data` is zero in every cycle where `res_valid` is low. After reset, `res_valid` is low until a trigger has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_we | input | 1 | Load strobe for the operand register |
| opnd_data | input | 16 | Operand word to load |
| trig_we | input | 1 | Trigger strobe, starts a multiply |
| trig_data | input | 16 | Trigger operand word |
| trig_frac | input | 1 | Mode with the trigger: 1 fractional, 0 integer |
| res_valid | output | 1 | Result strobe, one cycle per trigger |
| res_data | output | 16 | Result word, zero when not valid |

## Verification
Saturation needs scaled products at the very edge of the 1.5.10 range. It also needs the same-cycle operand write to land exactly on a trigger cycle, alongside a held operand reused across many triggers. The stimulus gets there in two parts. A corner phase sends every pair from a set of boundary words (0x7FFF, 0x8000, ±1.0, ±1 LSB, 0) with the operand written on the trigger cycle, and the mode alternates on every beat. A near-exhaustive grid then loads each operand once and streams about two hundred triggers against it in both modes, with garbage on the unused operand and mode inputs.

// File: rtl/fxmul_pkg.sv
package fxmul_pkg;
   typedef enum logic {
      MODE_INT  = 1'b0,
      MODE_FRAC = 1'b1
   } fxmul_mode_e;

   localparam int unsigned FXMUL_MIN_LATENCY = 2;
endpackage

// File: rtl/fxmul_opnd_reg.sv
module fxmul_opnd_reg #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              opnd_we,
   input  logic [WORD_W-1:0] opnd_data,
   output logic [WORD_W-1:0] opnd_q,
   output logic [WORD_W-1:0] opnd_eff
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opnd_q <= '0;
      end else if (opnd_we) begin
         opnd_q <= opnd_data;
      end
   end

   // same-cycle write reaches the trigger
   assign opnd_eff = opnd_we ? opnd_data : opnd_q;
endmodule

// File: rtl/fxmul_core.sv
module fxmul_core
   import fxmul_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned FRAC_W = 10,
   parameter bit          SAT_EN = 1'b1
) (
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  fxmul_mode_e       mode,
   output logic [WORD_W-1:0] res
);
   localparam int unsigned PROD_W = 2 * WORD_W;
   localparam int unsigned TOP_LO = FRAC_W + WORD_W - 1;
   localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};
   localparam logic [WORD_W-1:0] NEG_MAX = {1'b1, {(WORD_W-1){1'b0}}};

   logic signed [PROD_W-1:0] prod;
   logic [WORD_W-1:0]        frac_raw;
   logic [WORD_W-1:0]        frac_res;

   assign prod     = $signed(a) * $signed(b);
   assign frac_raw = prod[FRAC_W+WORD_W-1:FRAC_W];

   if (SAT_EN) begin : g_sat
      logic [PROD_W-TOP_LO-1:0] top_bits;
      logic                     ovf;
      assign top_bits = prod[PROD_W-1:TOP_LO];
      assign ovf      = !((&top_bits) || !(|top_bits));
      assign frac_res = ovf ? (prod[PROD_W-1] ? NEG_MAX : POS_MAX) : frac_raw;
   end else begin : g_wrap
      assign frac_res = frac_raw;
   end

   assign res = (mode == MODE_FRAC) ? frac_res : prod[WORD_W-1:0];
endmodule

// File: rtl/fxmul_pipe.sv
module fxmul_pipe #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_data,
   output logic         out_vld,
   output logic [W-1:0] out_data
);
   logic [DEPTH-1:0] vld_q;
   logic [W-1:0]     dat_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic         nxt_vld;
      logic [W-1:0] nxt_dat;
      if (i == 0) begin : g_head
         assign nxt_vld = in_vld;
         assign nxt_dat = in_vld ? in_data : '0;
      end else begin : g_body
         assign nxt_vld = vld_q[i-1];
         assign nxt_dat = dat_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[i] <= 1'b0;
            dat_q[i] <= '0;
         end else begin
            vld_q[i] <= nxt_vld;
            dat_q[i] <= nxt_dat;
         end
      end
   end

   assign out_vld  = vld_q[DEPTH-1];
   assign out_data = dat_q[DEPTH-1];
endmodule

// File: rtl/fxmul_unit.sv
module fxmul_unit
   import fxmul_pkg::*;
#(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned FRAC_W  = 10,
   parameter int unsigned LATENCY = 2,
   parameter bit          SAT_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              opnd_we,
   input  logic [WORD_W-1:0] opnd_data,
   input  logic              trig_we,
   input  logic [WORD_W-1:0] trig_data,
   input  logic              trig_frac,
   output logic              res_valid,
   output logic [WORD_W-1:0] res_data
);
   localparam int unsigned TAIL = LATENCY - 1;

   if (WORD_W < 2) begin : g_bad_width
      $error("fxmul_unit: WORD_W must be at least 2");
   end
   if (FRAC_W >= WORD_W) begin : g_bad_frac
      $error("fxmul_unit: FRAC_W must be below WORD_W");
   end
   if (LATENCY < FXMUL_MIN_LATENCY) begin : g_bad_lat
      $error("fxmul_unit: LATENCY below the minimum of two");
   end

   logic [WORD_W-1:0] opnd_q;
   logic [WORD_W-1:0] opnd_eff;
   logic [WORD_W-1:0] s1_a, s1_b;
   fxmul_mode_e       s1_mode;
   logic              s1_vld;
   logic [WORD_W-1:0] core_res;

   fxmul_opnd_reg #(.WORD_W(WORD_W)) u_opnd (
      .clk      (clk),
      .rst_n    (rst_n),
      .opnd_we  (opnd_we),
      .opnd_data(opnd_data),
      .opnd_q   (opnd_q),
      .opnd_eff (opnd_eff)
   );

   // stage 1: capture both operands and the mode on the trigger
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_a    <= '0;
         s1_b    <= '0;
         s1_mode <= MODE_INT;
         s1_vld  <= 1'b0;
      end else begin
         s1_vld <= trig_we;
         if (trig_we) begin
            s1_a    <= opnd_eff;
            s1_b    <= trig_data;
            s1_mode <= fxmul_mode_e'(trig_frac);
         end
      end
   end

   fxmul_core #(
      .WORD_W(WORD_W),
      .FRAC_W(FRAC_W),
      .SAT_EN(SAT_EN)
   ) u_core (
      .a   (s1_a),
      .b   (s1_b),
      .mode(s1_mode),
      .res (core_res)
   );

   // remaining stages: product, format and any extra delay
   fxmul_pipe #(.W(WORD_W), .DEPTH(TAIL)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (s1_vld),
      .in_data (core_res),
      .out_vld (res_valid),
      .out_data(res_data)
   );
endmodule

// File: rtl/fxmul_unit_chk.sv
module fxmul_unit_chk #(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned LATENCY = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              opnd_we,
   input logic              trig_we,
   input logic [WORD_W-1:0] trig_data,
   input logic [WORD_W-1:0] opnd_q,
   input logic              res_valid,
   input logic [WORD_W-1:0] res_data
);
   logic [LATENCY-1:0] vld_sh;
   logic [LATENCY-1:0] zero_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_sh  <= '0;
         zero_sh <= '0;
      end else begin
         vld_sh  <= {vld_sh[LATENCY-2:0], trig_we};
         zero_sh <= {zero_sh[LATENCY-2:0], trig_we && (trig_data == '0)};
      end
   end

   // R5
   vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid == vld_sh[LATENCY-1]);

   // R8
   data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (res_data == '0));

   // R6
   opnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !opnd_we |=> $stable(opnd_q));

   // R1
   zero_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && zero_sh[LATENCY-1]) |-> (res_data == '0));
endmodule

bind fxmul_unit fxmul_unit_chk #(.WORD_W(WORD_W), .LATENCY(LATENCY)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .opnd_we  (opnd_we),
   .trig_we  (trig_we),
   .trig_data(trig_data),
   .opnd_q   (opnd_q),
   .res_valid(res_valid),
   .res_data (res_data)
);

// File: tb/fxmul_unit_tb.sv
module fxmul_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        opnd_we = 1'b0;
   logic [15:0] opnd_data = '0;
   logic        trig_we = 1'b0;
   logic [15:0] trig_data = '0;
   logic        trig_frac = 1'b0;
   logic        res_valid;
   logic [15:0] res_data;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [15:0] held = '0;
   logic        e1_v = 1'b0, e2_v = 1'b0;
   logic [15:0] e1_d = '0, e2_d = '0;
   string       e1_t = "R5", e2_t = "R5";

   always #10 clk = ~clk;

   fxmul_unit u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .opnd_we  (opnd_we),
      .opnd_data(opnd_data),
      .trig_we  (trig_we),
      .trig_data(trig_data),
      .trig_frac(trig_frac),
      .res_valid(res_valid),
      .res_data (res_data)
   );

   function automatic logic [15:0] model(logic [15:0] a, logic [15:0] b, logic frac);
      longint p = longint'($signed(a)) * longint'($signed(b));
      longint q = p >>> 10;
      if (!frac) return p[15:0];
      if (q > 32767)  return 16'h7FFF;
      if (q < -32768) return 16'h8000;
      return q[15:0];
   endfunction

   function automatic bit is_sat(logic [15:0] a, logic [15:0] b);
      longint p = longint'($signed(a)) * longint'($signed(b));
      longint q = p >>> 10;
      return (q > 32767) || (q < -32768);
   endfunction

   // one clock: check the result of two beats ago, then drive this beat
   task automatic beat(input logic owe, input logic [15:0] od,
                       input logic twe, input logic [15:0] td, input logic frac);
      string tag;
      @(negedge clk);
      n_tests++;
      if (res_valid !== e2_v) begin
         n_fail++;
         $display("FAIL R5: res_valid=%0b expected %0b", res_valid, e2_v);
      end else if (res_data !== e2_d) begin
         n_fail++;
         $display("FAIL %s: res_data=%h expected %h", e2_t, res_data, e2_d);
      end
      e2_v = e1_v; e2_d = e1_d; e2_t = e1_t;
      if (owe) held = od;
      e1_v = twe;
      e1_d = twe ? model(held, td, frac) : 16'h0000;
      if (!twe)                    tag = "R8";
      else if (owe)                tag = "R7";
      else if (frac && is_sat(held, td)) tag = "R2";
      else if (frac)               tag = "R1";
      else                         tag = "R3";
      e1_t = tag;
      opnd_we   = owe;
      opnd_data = od;
      trig_we   = twe;
      trig_data = td;
      trig_frac = frac;
   endtask

   initial begin
      logic [15:0] corners [12];
      corners = '{16'h7FFF, 16'h8000, 16'h0400, 16'hFC00, 16'h0001, 16'hFFFF,
                  16'h0000, 16'h7C00, 16'h8400, 16'h0B50, 16'hF4B0, 16'h2000};
      repeat (3) @(negedge clk);
      n_tests++;
      if (res_valid !== 1'b0 || res_data !== 16'h0000) begin
         n_fail++;
         $display("FAIL R8: reset res_valid=%0b res_data=%h expected 0 0000", res_valid, res_data);
      end
      rst_n = 1'b1;

      // R7/R2/R1/R3: boundary pairs, operand written on the trigger cycle, mode alternating
      for (int i = 0; i < 12; i++) begin
         for (int j = 0; j < 12; j++) begin
            beat(1'b1, corners[i], 1'b1, corners[j], 1'b1);
            beat(1'b1, corners[j], 1'b1, corners[i], 1'b0);
         end
      end

      // R5/R4/R8: isolated triggers, mode and data toggled on idle cycles
      for (int k = 0; k < 6; k++) begin
         beat(1'b0, 16'hDEAD, 1'b1, corners[k], k[0]);
         beat(1'b0, 16'hBEEF, 1'b0, 16'h5A5A, ~k[0]);
         beat(1'b0, 16'h1234, 1'b0, 16'hA5A5, k[0]);
         beat(1'b0, 16'h4321, 1'b0, 16'h0F0F, ~k[0]);
      end

      // R6/R1/R2/R3: grid sweep, operand loaded once then reused by streamed triggers
      for (int i = 0; i < 198; i++) begin
         logic [15:0] av = 16'(-32768 + i * 331);
         beat(1'b1, av, 1'b0, 16'h0000, 1'b0);
         for (int j = 0; j < 198; j++) begin
            logic [15:0] bv = 16'(-32768 + j * 331 + 7);
            beat(1'b0, ~av, 1'b1, bv, 1'b1);
            beat(1'b0, av ^ 16'h00F0, 1'b1, bv, 1'b0);
         end
      end

      repeat (4) beat(1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL R5: watchdog expired, actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule